// File: doc/BRIEF.md
# Ripple-Sliced Integer ALU with Signed Less-Than

This block is a purely combinational integer arithmetic logic unit for a processor datapath. It has no clock or reset. Two W-bit operands and a 3-bit operation code go in. A W-bit result comes out, along with three flags: zero, signed overflow and carry. The default W is 32.

The datapath is a chain of W identical one-bit cells. Each cell can complement its `a` bit and its `b` bit. A full adder follows, and then a four-way selector picks one of four values: AND, OR, the adder sum, or a "less" input. One negate line, taken from the top bit of the operation code, does two jobs: it complements every `b` bit and it sets the carry into cell 0. Subtraction therefore needs no extra hardware.

For the less-than operation, the raw sign of `a - b` leaves the top cell and is wired back into the less input of cell 0. The less inputs of all other cells are held at 0. The raw sign is used as it is, with no overflow correction.

Top module: `bs_alu32`

## Requirements
- R1: Code 3'b000 gives `a & b` on every bit; code 3'b001 gives `a | b` on every bit.
- R2: Code 3'b010 gives `(a + b) mod 2^W` on the result. `cout_o` is bit W of the unsigned sum.
- R3: Code 3'b110 gives `(a - b) mod 2^W` on the result. `cout_o` is 1 exactly when `a >= b` as unsigned numbers, because the adder computes `a + ~b + 1`.
- R4: Code 3'b111 drives result bits W-1..1 to 0. Result bit 0 is bit W-1 of the wrapped difference `(a - b) mod 2^W`, with no correction for overflow. For example, 32'h8000_0000 less-than 1 gives 0.
- R5: `zero_o` is 1 exactly when every result bit is 0, for every operation code. Under code 3'b110 it is therefore 1 exactly when `a == b`.
- R6: Under codes 3'b010 and 3'b110, `ovf_o` is 1 exactly when the two's-complement result falls outside the signed W-bit range. Under the logic codes its value is unspecified.
- R7: Code 3'b100 gives `~(a | b)`, formed by complementing both operands and taking the AND path. Code 3'b101 gives `~(a & b)`, formed by complementing both operands and taking the OR path.
- R8: Under code 3'b111, `cout_o` and `ovf_o` take the same values they take under code 3'b110 for the same operands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 3 | Operation code (encodings in R1 to R8) |
| a_i | input | W | First operand |
| b_i | input | W | Second operand |
| result_o | output | W | Selected result |
| zero_o | output | 1 | High when every result bit is 0 |
| ovf_o | output | 1 | Signed overflow of the add/subtract chain |
| cout_o | output | 1 | Carry out of the top cell |

## Verification
The block holds no state, so a wrong internal value shows up at the ports in the same evaluation as the input pattern that excites it.

Different faults leave different marks:
- A broken link in the carry chain corrupts the result from the faulty cell upward. It also corrupts `cout_o`, and it can flip the fed-back sign that less-than depends on.
- A wrong negate or invert control shows up first as a wrong difference or a wrong NOR/NAND.
- A misrouted less path gives a non-zero upper result under code 3'b111, or a bit 0 that disagrees with the raw difference sign.

The overflowing less-than cases and the equal-operand subtractions are where a fault in the sign feedback or the zero flag separates from correct behaviour.

// File: rtl/bs_alu_pkg.sv
package bs_alu_pkg;

  typedef enum logic [2:0] {
    OP_AND  = 3'b000,
    OP_OR   = 3'b001,
    OP_ADD  = 3'b010,
    OP_NOR  = 3'b100,
    OP_NAND = 3'b101,
    OP_SUB  = 3'b110,
    OP_SLT  = 3'b111
  } alu_op_e;

  typedef enum logic [1:0] {
    SEL_AND  = 2'd0,
    SEL_OR   = 2'd1,
    SEL_SUM  = 2'd2,
    SEL_LESS = 2'd3
  } cell_sel_e;

  function automatic logic fa_sum(input logic x, input logic y, input logic ci);
    return x ^ y ^ ci;
  endfunction

  function automatic logic fa_carry(input logic x, input logic y, input logic ci);
    return (x & y) | (x & ci) | (y & ci);
  endfunction

  function automatic logic pick4(input cell_sel_e s, input logic v_and,
                                 input logic v_or, input logic v_sum,
                                 input logic v_less);
    logic r;
    unique case (s)
      SEL_AND:  r = v_and;
      SEL_OR:   r = v_or;
      SEL_SUM:  r = v_sum;
      default:  r = v_less;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/bs_slice.sv
module bs_slice
  import bs_alu_pkg::*;
(
  input  logic      a,
  input  logic      b,
  input  logic      a_inv,
  input  logic      b_inv,
  input  logic      cin,
  input  logic      less,
  input  cell_sel_e sel,
  output logic      res,
  output logic      sum,
  output logic      cout
);
  logic a_eff;
  logic b_eff;

  always_comb begin
    a_eff = a ^ a_inv;
    b_eff = b ^ b_inv;
    sum   = fa_sum(a_eff, b_eff, cin);
    cout  = fa_carry(a_eff, b_eff, cin);
    res   = pick4(sel, a_eff & b_eff, a_eff | b_eff, sum, less);
  end

endmodule

// File: rtl/bs_ctrl.sv
module bs_ctrl
  import bs_alu_pkg::*;
(
  input  logic [2:0] op,
  output logic       a_inv,
  output logic       b_neg,
  output cell_sel_e  sel
);
  always_comb begin
    // top code bit negates b and seeds the carry; the 10x codes also complement a
    b_neg = op[2];
    a_inv = op[2] & ~op[1];
    sel   = cell_sel_e'(op[1:0]);
  end

endmodule

// File: rtl/bs_flags.sv
module bs_flags #(
  parameter int W = 32
) (
  input  logic [W-1:0] result,
  input  logic         c_into_msb,
  input  logic         c_out_msb,
  output logic         zero,
  output logic         ovf
);
  always_comb begin
    zero = ~|result;
    ovf  = c_into_msb ^ c_out_msb;
  end

endmodule

// File: rtl/bs_alu32.sv
module bs_alu32
  import bs_alu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [2:0]   op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] result_o,
  output logic         zero_o,
  output logic         ovf_o,
  output logic         cout_o
);
  localparam int MSB = W - 1;

  logic         a_inv_w;
  logic         b_neg_w;
  cell_sel_e    sel_w;
  logic         set_w;
  logic         c_into_msb_w;
  logic [W-1:0] sum_v;

  bs_ctrl u_ctrl (
    .op    (op_i),
    .a_inv (a_inv_w),
    .b_neg (b_neg_w),
    .sel   (sel_w)
  );

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic cin_w;
    logic less_w;
    logic res_w;
    logic sum_w;
    logic cout_w;

    if (i == 0) begin : g_lsb
      assign cin_w  = b_neg_w;
      assign less_w = set_w;
    end else begin : g_upper
      assign cin_w  = g_bit[i-1].cout_w;
      assign less_w = 1'b0;
    end

    bs_slice u_cell (
      .a     (a_i[i]),
      .b     (b_i[i]),
      .a_inv (a_inv_w),
      .b_inv (b_neg_w),
      .cin   (cin_w),
      .less  (less_w),
      .sel   (sel_w),
      .res   (res_w),
      .sum   (sum_w),
      .cout  (cout_w)
    );

    assign result_o[i] = res_w;
    assign sum_v[i]    = sum_w;
  end

  assign set_w        = sum_v[MSB];
  assign c_into_msb_w = g_bit[MSB].cin_w;
  assign cout_o       = g_bit[MSB].cout_w;

  bs_flags #(.W(W)) u_flags (
    .result     (result_o),
    .c_into_msb (c_into_msb_w),
    .c_out_msb  (cout_o),
    .zero       (zero_o),
    .ovf        (ovf_o)
  );

endmodule

// File: rtl/bs_alu32_chk.sv
module bs_alu32_chk #(
  parameter int W = 32
) (
  input logic [2:0]   op,
  input logic [W-1:0] a,
  input logic [W-1:0] b,
  input logic [W-1:0] result,
  input logic         zero,
  input logic         ovf,
  input logic         cout,
  input logic [W-1:0] sum_v
);
  logic [W:0]   add_full;
  logic [W-1:0] diff;
  logic         add_ovf;
  logic         sub_ovf;

  always_comb begin
    add_full = {1'b0, a} + {1'b0, b};
    diff     = a - b;
    add_ovf  = (a[W-1] == b[W-1]) && (add_full[W-1] != a[W-1]);
    sub_ovf  = (a[W-1] != b[W-1]) && (diff[W-1] != a[W-1]);

    if (op == 3'b000) p_and_r1: assert (result == (a & b));
    if (op == 3'b001) p_or_r1: assert (result == (a | b));
    if (op == 3'b010) p_add_r2: assert ({cout, result} == add_full);
    if (op == 3'b110) p_sub_r3: assert (result == diff && cout == (a >= b));
    if (op == 3'b110) p_sum_chain_r3: assert (sum_v == diff);
    if (op == 3'b111) p_slt_r4: assert (result == {{(W-1){1'b0}}, diff[W-1]});
    if (op == 3'b110) p_zero_eq_r5: assert (zero == (a == b));
    if (op == 3'b010) p_add_ovf_r6: assert (ovf == add_ovf);
    if (op == 3'b110) p_sub_ovf_r6: assert (ovf == sub_ovf);
    if (op == 3'b100) p_nor_r7: assert (result == ~(a | b));
    if (op == 3'b101) p_nand_r7: assert (result == ~(a & b));
    if (op == 3'b111) p_slt_flags_r8: assert (ovf == sub_ovf && cout == (a >= b));
  end

endmodule

bind bs_alu32 bs_alu32_chk #(.W(W)) u_chk (
  .op     (op_i),
  .a      (a_i),
  .b      (b_i),
  .result (result_o),
  .zero   (zero_o),
  .ovf    (ovf_o),
  .cout   (cout_o),
  .sum_v  (sum_v)
);

// File: tb/bs_alu32_tb_top.sv
module bs_alu32_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic [2:0]  op_d = 3'b000;
  logic [31:0] a_d = '0;
  logic [31:0] b_d = '0;
  logic [31:0] res_w;
  logic        zero_w;
  logic        ovf_w;
  logic        cout_w;

  int n_chk  = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bs_alu32 dut_i (
    .op_i     (op_d),
    .a_i      (a_d),
    .b_i      (b_d),
    .result_o (res_w),
    .zero_o   (zero_w),
    .ovf_o    (ovf_w),
    .cout_o   (cout_w)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s op=%b a=%h b=%h actual=%h expected=%h",
               req, op_d, a_d, b_d, act, exp);
    end
  endtask

  task automatic run(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b);
    longint ua, ub, sa, sb, wide, sgn;
    logic [31:0] exp_res;
    logic        exp_cout, exp_ovf;
    string       tag;
    @(posedge clk);
    #1;
    op_d = op; a_d = a; b_d = b;
    @(negedge clk);
    ua = longint'({32'b0, a});
    ub = longint'({32'b0, b});
    sa = longint'($signed(a));
    sb = longint'($signed(b));
    exp_cout = 1'b0;
    exp_ovf  = 1'b0;
    case (op)
      3'b000: begin exp_res = a & b;    tag = "R1 and"; end
      3'b001: begin exp_res = a | b;    tag = "R1 or"; end
      3'b100: begin exp_res = ~(a | b); tag = "R7 nor"; end
      3'b101: begin exp_res = ~(a & b); tag = "R7 nand"; end
      3'b010: begin
        wide = ua + ub; sgn = sa + sb;
        exp_res = wide[31:0]; exp_cout = wide[32];
        exp_ovf = (sgn > 64'sd2147483647) || (sgn < -64'sd2147483648);
        tag = "R2 add";
      end
      default: begin
        wide = ua - ub; sgn = sa - sb;
        exp_cout = (ua >= ub);
        exp_ovf = (sgn > 64'sd2147483647) || (sgn < -64'sd2147483648);
        if (op == 3'b111) begin
          exp_res = {31'b0, wide[31]}; tag = "R4 slt";
        end else begin
          exp_res = wide[31:0]; tag = "R3 sub";
        end
      end
    endcase
    check(res_w === exp_res, tag, res_w, exp_res);
    check(zero_w === (exp_res == 32'b0), "R5 zero", {31'b0, zero_w},
          {31'b0, exp_res == 32'b0});
    if (op == 3'b010 || op == 3'b110) begin
      check(cout_w === exp_cout, op[2] ? "R3 cout" : "R2 cout", {31'b0, cout_w}, {31'b0, exp_cout});
      check(ovf_w === exp_ovf, "R6 ovf", {31'b0, ovf_w}, {31'b0, exp_ovf});
    end
    if (op == 3'b111) begin
      check(cout_w === exp_cout, "R8 slt cout", {31'b0, cout_w}, {31'b0, exp_cout});
      check(ovf_w === exp_ovf, "R8 slt ovf", {31'b0, ovf_w}, {31'b0, exp_ovf});
    end
  endtask

  initial begin
    logic [31:0] st;
    logic [31:0] ra, rb;
    logic [2:0]  ops [7];
    ops = '{3'b000, 3'b001, 3'b010, 3'b100, 3'b101, 3'b110, 3'b111};
    // initial state: AND of zeros
    @(negedge clk);
    check(res_w === 32'b0, "R1 initial result", res_w, 32'b0);
    check(zero_w === 1'b1, "R5 initial zero", {31'b0, zero_w}, 32'd1);

    run(3'b000, 32'hF0F0_1234, 32'hFF00_00FF);   // R1
    run(3'b001, 32'hF0F0_1234, 32'h0F00_0F00);   // R1
    run(3'b010, 32'hFFFF_FFFF, 32'h0000_0001);   // R2 carry, zero
    run(3'b010, 32'h7FFF_FFFF, 32'h0000_0001);   // R6 positive overflow
    run(3'b010, 32'h8000_0000, 32'h8000_0000);   // R6 negative overflow
    run(3'b110, 32'h1234_5678, 32'h1234_5678);   // R5 equality
    run(3'b110, 32'h8000_0000, 32'h0000_0001);   // R6 sub overflow
    run(3'b110, 32'h0000_0003, 32'h0000_0005);   // R3 borrow
    run(3'b111, 32'h0000_0003, 32'h0000_0005);   // R4 true
    run(3'b111, 32'h0000_0005, 32'h0000_0003);   // R4 false
    run(3'b111, 32'hFFFF_FFFF, 32'h0000_0001);   // R4 negative vs positive
    run(3'b111, 32'h8000_0000, 32'h0000_0001);   // R4 raw sign, overflowing
    run(3'b111, 32'h7FFF_FFFF, 32'hFFFF_FFFF);   // R4 raw sign, overflowing
    run(3'b111, 32'hCAFE_0000, 32'hCAFE_0000);   // R4 equal
    run(3'b100, 32'h0F0F_0000, 32'h00FF_00F0);   // R7
    run(3'b101, 32'h0F0F_FFFF, 32'h00FF_F0F0);   // R7

    st = 32'h1357_9BDF;
    for (int i = 0; i < 350; i++) begin
      st = st ^ (st << 13); st = st ^ (st >> 17); st = st ^ (st << 5);
      ra = st;
      st = st ^ (st << 13); st = st ^ (st >> 17); st = st ^ (st << 5);
      rb = (i % 5 == 0) ? ra : st;
      run(ops[i % 7], ra, rb);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=<%0d", WATCHDOG, WATCHDOG);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule